// File: doc/BRIEF.md
# External Data Space Router with On-Chip RAM Overlay

This block sits between an 8-bit microcontroller core and two data stores. Each data-space transfer from the core carries a 24-bit byte address, a direction and write data, and is started by a single-clock request pulse. The router decides whether the transfer targets a 2 KB on-chip synchronous RAM or the off-chip bus. It then runs the transfer for a fixed number of machine cycles and returns a one-clock acknowledge together with registered read data.

A configuration input turns the overlay on or off. With the overlay on, the lowest 2 KB of the 24-bit space is served by the on-chip RAM. During such accesses the off-chip address, data and strobe pins are left untouched, so that they can serve as general-purpose I/O. Every other address goes off chip, with active-low read and write strobes that stay low for the whole access. Off-chip accesses last four machine cycles plus a programmable wait count. A machine cycle is one pulse of a prescaler enable input.

Top module: `xdata_router`

## Requirements
- R1: With `ovl_en` = 0, every address from 000000h to FFFFFFh is routed off chip and the on-chip RAM is never enabled.
- R2: With `ovl_en` = 1, addresses 000000h to 0007FFh are routed to the on-chip RAM. Its address is bits 10:0 of the request, it gets one `iram_en` pulse, and `iram_we` follows the direction.
- R3: With `ovl_en` = 1, addresses 000800h and above are routed off chip.
- R4: During an on-chip access, `ext_rd_n` and `ext_wr_n` stay high, `ext_wdata_oe` stays low, and `ext_addr` and `ext_wdata` keep the values they had before the access.
- R5: During an off-chip access, `ext_addr` carries the full 24-bit request address. A read holds `ext_rd_n` low. A write holds `ext_wr_n` low and `ext_wdata_oe` high, with `ext_wdata` equal to the request data. The two strobes are never low together.
- R6: An off-chip access lasts 4+n `mc_tick` pulses, where n is `wait_n` (0 to 7) sampled in the request cycle. Later changes of `wait_n` do not affect the access in progress.
- R7: An on-chip access lasts exactly 4 `mc_tick` pulses whatever the value of `wait_n`.
- R8: `ack` rises in the clock after the final machine-cycle pulse and stays high for exactly one clock. For a read, `rdata` holds the read byte while `ack` is high. On-chip reads return the RAM byte. Off-chip reads return `ext_rdata` as sampled on the final pulse.
- R9: A request pulse that arrives while an access is in progress is ignored. It produces no second acknowledge and does not change the address on the bus.
- R10: After reset, `ack` and `iram_en` are low, both strobes are high and `ext_wdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | Machine-cycle enable pulse from the prescaler |
| ovl_en | input | 1 | On-chip RAM overlay enable |
| wait_n | input | 3 | Off-chip wait count n |
| req | input | 1 | One-clock access request |
| we | input | 1 | Direction, 1 = write |
| addr | input | 24 | Request byte address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Registered read data |
| iram_en | output | 1 | On-chip RAM access enable |
| iram_we | output | 1 | On-chip RAM write enable |
| iram_addr | output | 11 | On-chip RAM address |
| iram_wdata | output | 8 | On-chip RAM write data |
| iram_rdata | input | 8 | On-chip RAM read data, one clock after enable |
| ext_addr | output | 24 | Off-chip address bus |
| ext_wdata | output | 8 | Off-chip write data |
| ext_wdata_oe | output | 1 | Off-chip data drive enable |
| ext_rd_n | output | 1 | Off-chip read strobe, active low |
| ext_wr_n | output | 1 | Off-chip write strobe, active low |
| ext_rdata | input | 8 | Off-chip read data |

## Verification
The bench sweeps the overlay setting, every wait count, both directions and both machine-cycle rates over addresses that include both sides of the 0007FFh/000800h edge, the top of the space, and addresses whose upper bits alone rule out the overlay. A decoder that compared too few address bits would send 800h or 123456h to the on-chip RAM. A design that ignored the overlay bit would hit the RAM when it should not. During every access the bench changes `wait_n` and issues a stray request, so a design that reads the wait count live or accepts requests while busy shows a wrong tick count or a second acknowledge. It also watches the off-chip pins through on-chip accesses, which catches a bus that leaks the internal address or pulses a strobe.

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int AW   = 24,
  parameter int DW   = 8,
  parameter int IAW  = 11,
  parameter int WW   = 3,
  parameter int BASE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mc_tick,
  input  logic          ovl_en,
  input  logic [WW-1:0] wait_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          iram_en,
  output logic          iram_we,
  output logic [IAW-1:0] iram_addr,
  output logic [DW-1:0] iram_wdata,
  input  logic [DW-1:0] iram_rdata,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  output logic          ext_wdata_oe,
  output logic          ext_rd_n,
  output logic          ext_wr_n,
  input  logic [DW-1:0] ext_rdata
);
  localparam int CW = $clog2(BASE + (1 << WW));

  logic          busy, is_int, we_q, iram_cap;
  logic [CW-1:0] cnt, tgt;
  logic [DW-1:0] idata;

  wire hit_int = ovl_en && (addr[AW-1:IAW] == '0);
  wire accept  = req && !busy;
  wire last    = busy && mc_tick && (cnt == CW'(tgt - 1'b1));
  wire ext_act = busy && !is_int;

  assign iram_we      = iram_en && we_q;
  assign ext_rd_n     = !(ext_act && !we_q);
  assign ext_wr_n     = !(ext_act && we_q);
  assign ext_wdata_oe = ext_act && we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; is_int <= 1'b0; we_q <= 1'b0;
      cnt <= '0; tgt <= '0;
      ack <= 1'b0; rdata <= '0;
      iram_en <= 1'b0; iram_cap <= 1'b0; idata <= '0;
      iram_addr <= '0; iram_wdata <= '0;
      ext_addr <= '0; ext_wdata <= '0;
    end else begin
      ack      <= last;
      iram_en  <= accept && hit_int;
      iram_cap <= iram_en && !we_q;
      if (accept) begin
        busy   <= 1'b1;
        is_int <= hit_int;
        we_q   <= we;
        cnt    <= '0;
        tgt    <= hit_int ? CW'(BASE) : CW'(BASE) + CW'(wait_n);
        if (hit_int) begin
          iram_addr  <= addr[IAW-1:0];
          iram_wdata <= wdata;
        end else begin
          ext_addr  <= addr;
          ext_wdata <= wdata;
        end
      end else if (busy && mc_tick) begin
        if (last) busy <= 1'b0;
        else      cnt  <= cnt + 1'b1;
      end
      if (iram_cap) idata <= iram_rdata;
      if (last && !we_q) rdata <= is_int ? idata : ext_rdata;
    end
  end

  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  a_r8_ack_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(busy) && !busy);
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));
  a_r4_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_int) |-> (ext_rd_n && ext_wr_n && !ext_wdata_oe));
  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_int) |-> $stable(ext_addr) && $stable(ext_wdata));
  a_r2_iram_overlay: assert property (@(posedge clk) disable iff (!rst_n)
    iram_en |-> $past(ovl_en) && busy && is_int);
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < tgt);
  a_r9_tgt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tgt) && $stable(is_int));
endmodule

// File: tb/tb_xdata_router.sv
module tb_xdata_router;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        mc_tick = 0, ovl_en = 0, req = 0, we = 0;
  logic [2:0]  wait_n = 0;
  logic [23:0] addr = 0;
  logic [7:0]  wdata = 0;
  logic        ack, iram_en, iram_we, ext_wdata_oe, ext_rd_n, ext_wr_n;
  logic [7:0]  rdata, iram_wdata, ext_wdata, ext_rdata;
  logic [7:0]  iram_rdata = 0;
  logic [10:0] iram_addr;
  logic [23:0] ext_addr;

  xdata_router dut (.*);

  int checks = 0, fails = 0;
  logic [7:0] mem [2048];
  logic [7:0] shadow [2048];

  function automatic logic [7:0] ext_fn(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  assign ext_rdata = ext_fn(ext_addr);

  always @(posedge clk) if (iram_en) begin
    if (iram_we) mem[iram_addr] <= iram_wdata;
    else iram_rdata <= mem[iram_addr];
  end

  logic [23:0] wa_seen; logic [7:0] wd_seen; logic oe_seen;
  always @(posedge clk) if (!ext_wr_n) begin
    wa_seen <= ext_addr; wd_seen <= ext_wdata; oe_seen <= ext_wdata_oe;
  end

  int div = 1, dcnt = 0;
  always @(negedge clk) begin
    mc_tick <= (dcnt == 0);
    dcnt <= (dcnt + 1 >= div) ? 0 : dcnt + 1;
  end
  int tick_cnt = 0, ien_cnt = 0;
  always @(posedge clk) begin
    tick_cnt <= tick_cnt + int'(mc_tick);
    ien_cnt  <= ien_cnt + int'(iram_en);
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic access(logic ovl, logic w, logic [23:0] a, logic [7:0] d, logic [2:0] n);
    logic inr; logic [23:0] pa; logic [7:0] pd; int s0, e0, dt; bit moved;
    inr = ovl && (a < 24'h800);
    @(negedge clk);
    pa = ext_addr; pd = ext_wdata; e0 = ien_cnt;
    ovl_en = ovl; we = w; addr = a; wdata = d; wait_n = n; req = 1;
    @(negedge clk);
    s0 = tick_cnt;
    req = 1; addr = a ^ 24'h000800; wait_n = ~n;
    if (inr) begin
      chk("R2 iram_addr", iram_addr, a[10:0]);
      chk("R2 iram_we", iram_we, w);
      chk("R4 rd_n", ext_rd_n, 1); chk("R4 wr_n", ext_wr_n, 1);
    end else begin
      chk(ovl ? "R3 ext_addr" : "R1 ext_addr", ext_addr, a);
      chk("R5 rd_n", ext_rd_n, w); chk("R5 wr_n", ext_wr_n, !w);
      chk("R5 oe", ext_wdata_oe, w);
    end
    @(negedge clk);
    req = 0;
    moved = 0;
    for (int i = 0; i < 400; i++) begin
      if (ack) break;
      if (inr && (!ext_rd_n || !ext_wr_n || ext_wdata_oe || ext_addr != pa || ext_wdata != pd)) moved = 1;
      @(negedge clk);
    end
    dt = tick_cnt - s0;
    chk("R8 ack seen", ack, 1);
    if (inr) begin
      chk("R7 ticks", dt, 4);
      chk("R4 pins quiet", moved, 0);
      chk("R2 one iram_en", ien_cnt - e0, 1);
      if (w) shadow[a[10:0]] = d;
      else chk("R8 iram rdata", rdata, shadow[a[10:0]]);
    end else begin
      chk("R6 ticks", dt, 4 + n);
      chk(ovl ? "R3 no iram" : "R1 no iram", ien_cnt - e0, 0);
      chk("R9 addr kept", ext_addr, a);
      if (w) begin
        chk("R5 wr addr", wa_seen, a); chk("R5 wr data", wd_seen, d);
        chk("R5 wr oe", oe_seen, 1);
      end else chk("R8 ext rdata", rdata, ext_fn(a));
    end
    @(negedge clk); chk("R8 ack one clk", ack, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R9 no second ack", ack, 0);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  logic [23:0] alist [6] = '{24'h000000, 24'h0007FF, 24'h000800, 24'hFFFFFF, 24'h123456, 24'h0003A5};

  initial begin
    for (int i = 0; i < 2048; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk("R10 ack", ack, 0); chk("R10 iram_en", iram_en, 0);
    chk("R10 rd_n", ext_rd_n, 1); chk("R10 wr_n", ext_wr_n, 1);
    chk("R10 oe", ext_wdata_oe, 0);
    rst_n = 1;
    foreach (alist[k]) begin
      for (int dv = 1; dv <= 3; dv += 2) begin
        div = dv;
        for (int ov = 0; ov < 2; ov++)
          for (int n = 0; n < 8; n++) begin
            access(ov[0], 1, alist[k], 8'(alist[k][7:0] + n * 17 + dv + ov * 3), 3'(n));
            access(ov[0], 0, alist[k], 8'h00, 3'(7 - n));
          end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule